// File: doc/BRIEF.md
# Fully Associative Translation Cache with Address-Space Tags

This block caches page translations for a memory-management unit. Each entry holds a virtual page number, an address-space tag, a global flag and the page-table entry word that belongs to that page. It does not hold a physical address. A lookup presents a page number and the current address-space tag. All entries are compared at once, and the hit flag and the cached page-table entry come back combinationally in the same cycle.

The page-table walker installs translations through a fill port. A fill goes into a free entry if one exists. Otherwise it replaces the least recently used entry. Entries with different address-space tags can hold the same page number side by side. An entry marked global matches under any tag. Software keeps the cache coherent with the page tables through two controls: one removes a single page number, and the other flushes every entry.

Top module: `xlat_cache`

## Requirements
- R1: When `lk_valid_i` is 1, `lk_hit_o` is 1 in the same cycle exactly when a valid entry has a page number equal to `lk_vpn_i` and either its tag equals `lk_asid_i` or its global flag is set. `lk_pte_o` then carries that entry's stored word. When `lk_valid_i` is 0, `lk_hit_o` is 0.
- R2: Entries with the same page number and different tags coexist. Each tag's lookup returns its own word, and a lookup under a third tag misses.
- R3: A global entry hits for every value of `lk_asid_i`.
- R4: A fill becomes visible to lookups from the cycle after `fill_valid_i` is sampled. A lookup in the fill cycle sees the old contents.
- R5: While any entry is free, a fill displaces no valid entry.
- R6: A fill that conflicts with a valid entry replaces that entry, so only one entry holds the translation. A conflict means equal page numbers and either equal tags or the global flag set on either side.
- R7: When the cache is full, a fill replaces the least recently used entry. Each lookup hit and each fill marks its entry most recently used. When a fill and a lookup hit fall in the same cycle, only the filled entry is marked.
- R8: `inv_valid_i` removes every entry whose page number equals `inv_vpn_i`, under any tag, from the next cycle on. Other entries are kept. A fill in the same cycle is applied after the removal.
- R9: `flush_i` empties the cache from the next cycle on. A fill or an invalidate in the same cycle is ignored.
- R10: After reset every lookup misses.
- R11: No more than one entry ever matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W | Lookup page number |
| lk_asid_i | input | ASID_W | Current address-space tag |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pte_o | output | PTE_W | Stored page-table entry of the hit |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | VPN_W | Page number to install |
| fill_asid_i | input | ASID_W | Tag to install |
| fill_glob_i | input | 1 | Installed entry matches every tag |
| fill_pte_i | input | PTE_W | Page-table entry word to install |
| inv_valid_i | input | 1 | Remove one page number |
| inv_vpn_i | input | VPN_W | Page number to remove |
| flush_i | input | 1 | Remove all entries |

## Verification
Lookups are tried in several setups. One page number is stored under two tags, which shows whether the tag takes part in matching. A global entry is looked up under unrelated tags, which shows whether the override works. Lookups in the same cycle as a fill show old contents against new. For replacement, the cache is filled to capacity, selected entries are touched, and evictions follow. One eviction is made while a competing lookup hits in the same cycle, and the entry that disappears shows whether the age order and the same-cycle touch priority are right. Invalidate is checked across tags and together with a same-cycle fill. Flush is checked together with a same-cycle fill.

// File: rtl/xc_pkg.sv
package xc_pkg;

    // Where a fill lands
    typedef enum logic [1:0] {
        SLOT_NONE     = 2'd0,
        SLOT_CONFLICT = 2'd1,
        SLOT_FREE     = 2'd2,
        SLOT_LRU      = 2'd3
    } slot_src_e;

endpackage

// File: rtl/xc_prio_enc.sv
module xc_prio_enc #(
    parameter int W  = 16,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // Lowest set bit wins
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/xc_tag_cmp.sv
module xc_tag_cmp #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic [ENTRIES-1:0]             vld_i,
    input  logic [ENTRIES-1:0]             glb_i,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_i,
    input  logic [ENTRIES-1:0][ASID_W-1:0] asid_i,
    input  logic [VPN_W-1:0]               lk_vpn_i,
    input  logic [ASID_W-1:0]              lk_asid_i,
    input  logic [VPN_W-1:0]               fill_vpn_i,
    input  logic [ASID_W-1:0]              fill_asid_i,
    input  logic                           fill_glob_i,
    input  logic [VPN_W-1:0]               inv_vpn_i,
    output logic [ENTRIES-1:0]             lk_vec_o,
    output logic [ENTRIES-1:0]             fill_vec_o,
    output logic [ENTRIES-1:0]             inv_vec_o
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic lk_pg, fill_pg, inv_pg;
        assign lk_pg   = vpn_i[e] == lk_vpn_i;
        assign fill_pg = vpn_i[e] == fill_vpn_i;
        assign inv_pg  = vpn_i[e] == inv_vpn_i;

        assign lk_vec_o[e]   = vld_i[e] & lk_pg
                             & (glb_i[e] | (asid_i[e] == lk_asid_i));
        assign fill_vec_o[e] = vld_i[e] & fill_pg
                             & (glb_i[e] | fill_glob_i | (asid_i[e] == fill_asid_i));
        assign inv_vec_o[e]  = vld_i[e] & inv_pg;
    end
endmodule

// File: rtl/xc_age_lru.sv
module xc_age_lru #(
    parameter int ENTRIES = 16,
    localparam int AW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en_i,
    input  logic [AW-1:0] touch_idx_i,
    output logic [AW-1:0] lru_idx_o
);
    // Ages form a permutation of 0..ENTRIES-1; 0 is newest
    typedef struct packed {
        logic [ENTRIES-1:0][AW-1:0] age;
    } age_t;

    localparam logic [AW-1:0] OLDEST = AW'(ENTRIES - 1);

    age_t st_d, st_q;
    logic [AW-1:0] touched_age;

    always_comb begin
        st_d        = st_q;
        touched_age = st_q.age[touch_idx_i];
        if (touch_en_i) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (AW'(j) == touch_idx_i) begin
                    st_d.age[j] = '0;
                end else if (st_q.age[j] < touched_age) begin
                    st_d.age[j] = st_q.age[j] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        lru_idx_o = '0;
        for (int j = 0; j < ENTRIES; j++) begin
            if (st_q.age[j] == OLDEST) lru_idx_o = AW'(j);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < ENTRIES; j++) st_q.age[j] <= AW'(j);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/xc_slot_pick.sv
module xc_slot_pick
    import xc_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int AW = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] vld_i,
    input  logic [ENTRIES-1:0] conf_vec_i,
    input  logic [AW-1:0]      lru_idx_i,
    output logic [AW-1:0]      slot_idx_o,
    output slot_src_e          src_o,
    output logic [ENTRIES-1:0] dup_clear_o
);
    logic          conf_any, free_any;
    logic [AW-1:0] conf_idx, free_idx;

    xc_prio_enc #(.W(ENTRIES)) i_conf_enc (
        .req_i (conf_vec_i),
        .any_o (conf_any),
        .idx_o (conf_idx)
    );

    xc_prio_enc #(.W(ENTRIES)) i_free_enc (
        .req_i (~vld_i),
        .any_o (free_any),
        .idx_o (free_idx)
    );

    always_comb begin
        if (conf_any) begin
            src_o      = SLOT_CONFLICT;
            slot_idx_o = conf_idx;
        end else if (free_any) begin
            src_o      = SLOT_FREE;
            slot_idx_o = free_idx;
        end else begin
            src_o      = SLOT_LRU;
            slot_idx_o = lru_idx_i;
        end
        dup_clear_o             = conf_vec_i;
        dup_clear_o[slot_idx_o] = 1'b0;
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xc_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int PTE_W   = 32,
    localparam int AW = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid_i,
    input  logic [VPN_W-1:0]  lk_vpn_i,
    input  logic [ASID_W-1:0] lk_asid_i,
    output logic              lk_hit_o,
    output logic [PTE_W-1:0]  lk_pte_o,
    input  logic              fill_valid_i,
    input  logic [VPN_W-1:0]  fill_vpn_i,
    input  logic [ASID_W-1:0] fill_asid_i,
    input  logic              fill_glob_i,
    input  logic [PTE_W-1:0]  fill_pte_i,
    input  logic              inv_valid_i,
    input  logic [VPN_W-1:0]  inv_vpn_i,
    input  logic              flush_i
);
    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0]             glb;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][ASID_W-1:0] asid;
        logic [ENTRIES-1:0][PTE_W-1:0]  pte;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    logic [ENTRIES-1:0] lk_match_vec, fill_conf_vec, inv_vec, dup_clear;
    logic               lk_any;
    logic [AW-1:0]      hit_idx, slot_idx, lru_idx, touch_idx;
    logic               fill_go, touch_en;
    slot_src_e          slot_src;

    xc_tag_cmp #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W)
    ) i_cmp (
        .vld_i       (tbl_q.vld),
        .glb_i       (tbl_q.glb),
        .vpn_i       (tbl_q.vpn),
        .asid_i      (tbl_q.asid),
        .lk_vpn_i    (lk_vpn_i),
        .lk_asid_i   (lk_asid_i),
        .fill_vpn_i  (fill_vpn_i),
        .fill_asid_i (fill_asid_i),
        .fill_glob_i (fill_glob_i),
        .inv_vpn_i   (inv_vpn_i),
        .lk_vec_o    (lk_match_vec),
        .fill_vec_o  (fill_conf_vec),
        .inv_vec_o   (inv_vec)
    );

    xc_prio_enc #(.W(ENTRIES)) i_hit_enc (
        .req_i (lk_match_vec),
        .any_o (lk_any),
        .idx_o (hit_idx)
    );

    xc_slot_pick #(.ENTRIES(ENTRIES)) i_pick (
        .vld_i       (tbl_q.vld),
        .conf_vec_i  (fill_conf_vec),
        .lru_idx_i   (lru_idx),
        .slot_idx_o  (slot_idx),
        .src_o       (slot_src),
        .dup_clear_o (dup_clear)
    );

    assign fill_go   = fill_valid_i & ~flush_i;
    assign lk_hit_o  = lk_valid_i & lk_any;
    assign lk_pte_o  = tbl_q.pte[hit_idx];
    assign touch_en  = fill_go | lk_hit_o;
    assign touch_idx = fill_go ? slot_idx : hit_idx;

    xc_age_lru #(.ENTRIES(ENTRIES)) i_lru (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_en_i  (touch_en),
        .touch_idx_i (touch_idx),
        .lru_idx_o   (lru_idx)
    );

    always_comb begin
        tbl_d = tbl_q;
        if (flush_i) begin
            tbl_d.vld = '0;
        end else begin
            if (inv_valid_i) tbl_d.vld = tbl_d.vld & ~inv_vec;
            if (fill_go) begin
                if (slot_src == SLOT_CONFLICT) tbl_d.vld = tbl_d.vld & ~dup_clear;
                tbl_d.vld[slot_idx]  = 1'b1;
                tbl_d.glb[slot_idx]  = fill_glob_i;
                tbl_d.vpn[slot_idx]  = fill_vpn_i;
                tbl_d.asid[slot_idx] = fill_asid_i;
                tbl_d.pte[slot_idx]  = fill_pte_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end
endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int PTE_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid_i,
    input logic [VPN_W-1:0]   lk_vpn_i,
    input logic [ASID_W-1:0]  lk_asid_i,
    input logic               lk_hit_o,
    input logic [PTE_W-1:0]   lk_pte_o,
    input logic               fill_valid_i,
    input logic [VPN_W-1:0]   fill_vpn_i,
    input logic [ASID_W-1:0]  fill_asid_i,
    input logic               fill_glob_i,
    input logic [PTE_W-1:0]   fill_pte_i,
    input logic               inv_valid_i,
    input logic [VPN_W-1:0]   inv_vpn_i,
    input logic               flush_i,
    input logic [ENTRIES-1:0] hit_vec
);
    p_single_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_idle_no_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |-> !lk_hit_o);

    p_fill_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid_i && !flush_i) |=>
        (!(lk_valid_i && lk_vpn_i == $past(fill_vpn_i)
           && (lk_asid_i == $past(fill_asid_i) || $past(fill_glob_i)))
         || (lk_hit_o && lk_pte_o == $past(fill_pte_i))));

    p_inv_removes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid_i && !fill_valid_i) |=>
        !(lk_hit_o && lk_vpn_i == $past(inv_vpn_i)));

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !lk_hit_o);
endmodule

bind xlat_cache xc_checker #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .ASID_W  (ASID_W),
    .PTE_W   (PTE_W)
) i_xc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid_i   (lk_valid_i),
    .lk_vpn_i     (lk_vpn_i),
    .lk_asid_i    (lk_asid_i),
    .lk_hit_o     (lk_hit_o),
    .lk_pte_o     (lk_pte_o),
    .fill_valid_i (fill_valid_i),
    .fill_vpn_i   (fill_vpn_i),
    .fill_asid_i  (fill_asid_i),
    .fill_glob_i  (fill_glob_i),
    .fill_pte_i   (fill_pte_i),
    .inv_valid_i  (inv_valid_i),
    .inv_vpn_i    (inv_vpn_i),
    .flush_i      (flush_i),
    .hit_vec      (lk_match_vec)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/100ps
module test_xlat_cache;
    localparam int ENTRIES = 16;
    localparam int VPN_W   = 20;
    localparam int ASID_W  = 8;
    localparam int PTE_W   = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid_i = 1'b0;
    logic [VPN_W-1:0]  lk_vpn_i = '0;
    logic [ASID_W-1:0] lk_asid_i = '0;
    logic              lk_hit_o;
    logic [PTE_W-1:0]  lk_pte_o;
    logic              fill_valid_i = 1'b0;
    logic [VPN_W-1:0]  fill_vpn_i = '0;
    logic [ASID_W-1:0] fill_asid_i = '0;
    logic              fill_glob_i = 1'b0;
    logic [PTE_W-1:0]  fill_pte_i = '0;
    logic              inv_valid_i = 1'b0;
    logic [VPN_W-1:0]  inv_vpn_i = '0;
    logic              flush_i = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    xlat_cache #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W),
        .PTE_W   (PTE_W)
    ) i_xlat_cache (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_valid_i   (lk_valid_i),
        .lk_vpn_i     (lk_vpn_i),
        .lk_asid_i    (lk_asid_i),
        .lk_hit_o     (lk_hit_o),
        .lk_pte_o     (lk_pte_o),
        .fill_valid_i (fill_valid_i),
        .fill_vpn_i   (fill_vpn_i),
        .fill_asid_i  (fill_asid_i),
        .fill_glob_i  (fill_glob_i),
        .fill_pte_i   (fill_pte_i),
        .inv_valid_i  (inv_valid_i),
        .inv_vpn_i    (inv_vpn_i),
        .flush_i      (flush_i)
    );

    task automatic expect_hit(input logic exp_hit, input logic [PTE_W-1:0] exp_pte,
                              input string req);
        n_chk++;
        if (lk_hit_o !== exp_hit || (exp_hit && lk_pte_o !== exp_pte)) begin
            n_bad++;
            $display("FAIL %s: hit=%0b pte=%h, expected hit=%0b pte=%h",
                     req, lk_hit_o, lk_pte_o, exp_hit, exp_pte);
        end
    endtask

    // Lookup held across one clock edge (a hit touches the age order)
    task automatic look(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                        input logic exp_hit, input logic [PTE_W-1:0] exp_pte,
                        input string req);
        @(negedge clk);
        lk_valid_i = 1'b1; lk_vpn_i = vpn; lk_asid_i = asid;
        #1 expect_hit(exp_hit, exp_pte, req);
        @(posedge clk); #1 lk_valid_i = 1'b0;
    endtask

    task automatic fill(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                        input logic glob, input logic [PTE_W-1:0] pte);
        @(negedge clk);
        fill_valid_i = 1'b1; fill_vpn_i = vpn; fill_asid_i = asid;
        fill_glob_i = glob; fill_pte_i = pte;
        @(posedge clk); #1 fill_valid_i = 1'b0;
    endtask

    task automatic fill_and_look(input logic [VPN_W-1:0] fvpn, input logic [PTE_W-1:0] fpte,
                                 input logic [VPN_W-1:0] lvpn, input logic [ASID_W-1:0] asid,
                                 input logic exp_hit, input logic [PTE_W-1:0] exp_pte,
                                 input string req);
        @(negedge clk);
        fill_valid_i = 1'b1; fill_vpn_i = fvpn; fill_asid_i = asid;
        fill_glob_i = 1'b0; fill_pte_i = fpte;
        lk_valid_i = 1'b1; lk_vpn_i = lvpn; lk_asid_i = asid;
        #1 expect_hit(exp_hit, exp_pte, req);
        @(posedge clk); #1 fill_valid_i = 1'b0; lk_valid_i = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk); flush_i = 1'b1;
        @(posedge clk); #1 flush_i = 1'b0;
    endtask

    task automatic t_reset();
        look(20'h00100, 8'd1, 1'b0, '0, "R10 empty after reset");
        look(20'h00000, 8'd0, 1'b0, '0, "R10 zero key after reset");
    endtask

    task automatic t_basic();
        fill_and_look(20'h00050, 32'hA000_0050, 20'h00050, 8'd1, 1'b0, '0,
                      "R4 fill-cycle lookup sees old contents");
        look(20'h00050, 8'd1, 1'b1, 32'hA000_0050, "R1 R4 hit after fill");
        @(negedge clk);
        lk_valid_i = 1'b0; lk_vpn_i = 20'h00050; lk_asid_i = 8'd1;
        #1 expect_hit(1'b0, '0, "R1 no hit without lookup request");
        look(20'h00051, 8'd1, 1'b0, '0, "R1 other page misses");
    endtask

    task automatic t_asid();
        fill(20'h00100, 8'd1, 1'b0, 32'h1111_0001);
        fill(20'h00100, 8'd2, 1'b0, 32'h2222_0002);
        look(20'h00100, 8'd1, 1'b1, 32'h1111_0001, "R2 tag 1 own word");
        look(20'h00100, 8'd2, 1'b1, 32'h2222_0002, "R2 tag 2 own word");
        look(20'h00100, 8'd3, 1'b0, '0, "R2 foreign tag misses");
    endtask

    task automatic t_global();
        fill(20'h00200, 8'd5, 1'b1, 32'h6000_0200);
        look(20'h00200, 8'd9,   1'b1, 32'h6000_0200, "R3 global under tag 9");
        look(20'h00200, 8'd255, 1'b1, 32'h6000_0200, "R3 global under tag 255");
    endtask

    task automatic t_dup();
        fill(20'h00100, 8'd1, 1'b0, 32'h1111_00FF);
        look(20'h00100, 8'd1, 1'b1, 32'h1111_00FF, "R6 refill replaces word");
        look(20'h00100, 8'd2, 1'b1, 32'h2222_0002, "R6 other tag untouched");
    endtask

    task automatic t_inval();
        @(negedge clk); inv_valid_i = 1'b1; inv_vpn_i = 20'h00100;
        @(posedge clk); #1 inv_valid_i = 1'b0;
        look(20'h00100, 8'd1, 1'b0, '0, "R8 removed under tag 1");
        look(20'h00100, 8'd2, 1'b0, '0, "R8 removed under tag 2");
        look(20'h00200, 8'd5, 1'b1, 32'h6000_0200, "R8 other page kept");
        // invalidate and fill of the same page in one cycle: fill survives
        @(negedge clk);
        inv_valid_i = 1'b1; inv_vpn_i = 20'h00050;
        fill_valid_i = 1'b1; fill_vpn_i = 20'h00050; fill_asid_i = 8'd1;
        fill_glob_i = 1'b0; fill_pte_i = 32'hB000_0050;
        @(posedge clk); #1 inv_valid_i = 1'b0; fill_valid_i = 1'b0;
        look(20'h00050, 8'd1, 1'b1, 32'hB000_0050, "R8 same-cycle fill applied after");
    endtask

    task automatic t_flush();
        @(negedge clk);
        flush_i = 1'b1;
        fill_valid_i = 1'b1; fill_vpn_i = 20'h00777; fill_asid_i = 8'd1;
        fill_glob_i = 1'b0; fill_pte_i = 32'h7777_7777;
        @(posedge clk); #1 flush_i = 1'b0; fill_valid_i = 1'b0;
        look(20'h00200, 8'd5, 1'b0, '0, "R9 global entry flushed");
        look(20'h00050, 8'd1, 1'b0, '0, "R9 entry flushed");
        look(20'h00777, 8'd1, 1'b0, '0, "R9 same-cycle fill ignored");
    endtask

    task automatic t_lru();
        do_flush();
        for (int i = 0; i < ENTRIES; i++)
            fill(VPN_W'(20'h01000 + i), 8'd1, 1'b0, 32'hC000_0000 + i);
        for (int i = 0; i < ENTRIES; i++)
            look(VPN_W'(20'h01000 + i), 8'd1, 1'b1, 32'hC000_0000 + i,
                 "R5 all fills kept while space free");
        look(20'h01000, 8'd1, 1'b1, 32'hC000_0000, "R7 touch oldest");
        fill(20'h02000, 8'd1, 1'b0, 32'hD000_2000);
        look(20'h01001, 8'd1, 1'b0, '0, "R7 oldest untouched evicted");
        look(20'h02000, 8'd1, 1'b1, 32'hD000_2000, "R7 new entry present");
        look(20'h01000, 8'd1, 1'b1, 32'hC000_0000, "R7 touched entry kept");
        fill_and_look(20'h03000, 32'hD000_3000, 20'h01003, 8'd1, 1'b1, 32'hC000_0003,
                      "R7 lookup hit during fill");
        look(20'h01002, 8'd1, 1'b0, '0, "R7 LRU replaced by fill");
        fill(20'h04000, 8'd1, 1'b0, 32'hD000_4000);
        look(20'h01003, 8'd1, 1'b0, '0, "R7 same-cycle hit did not refresh");
        look(20'h01004, 8'd1, 1'b1, 32'hC000_0004, "R7 next entry kept");
        look(20'h04000, 8'd1, 1'b1, 32'hD000_4000, "R7 latest fill present");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_asid();
        t_global();
        t_dup();
        t_inval();
        t_flush();
        t_lru();
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule